// File: doc/BRIEF.md
# Radix-4 Tree Lookahead Adder

This block is a purely combinational adder of two `WIDTH`-bit operands plus a carry-in. It returns a `WIDTH`-bit sum and a carry-out. `WIDTH` must be a power of four that is at least 4, for example 16 or 64.

Each bit position first produces its own generate (`a & b`) and propagate (`a ^ b`) flags. Four-input group cells merge four (propagate, generate) pairs into one group pair. These cells are stacked as a 4-ary tree, so the path from the leaves to the root passes through log4(`WIDTH`) cells.

Carries then flow back down the same tree. The root receives the external carry-in. Each group cell hands its four children their carries-in, using the group signals of the siblings below them. Every sum bit is the bit propagate XOR the carry arriving at that bit. The carry-out is the root generate, OR the root propagate AND the carry-in.

There is no data stream, so the ports are plain combinational wires. The port has no valid/ready handshake and no back-pressure.

Top module: `cla_tree_adder`

## Requirements
- R1: For every operand pair and carry-in, `{cout_o, sum_o}` equals the `WIDTH+1`-bit value `a_i + b_i + cin_i`.
- R2: When no bit position generates (`a_i & b_i` is zero) and `cin_i` is 0, the sum is `a_i | b_i` and `cout_o` is 0.
- R3: When the whole word generates a carry regardless of carry-in (for example both operands all ones), `cout_o` is 1 for both values of `cin_i`.
- R4: When every bit propagates (`a_i ^ b_i` all ones), `cout_o` equals `cin_i` and every sum bit equals the inverse of `cin_i`.
- R5: A carry generated at bit 0, with every higher bit propagating, reaches the carry-out and clears every sum bit.
- R6: A carry leaving the top bit of a 4-bit group, or of a 16-bit group, arrives at the lowest bit of the next group.
- R7: Alternating bit patterns (0101… and 1010…) add correctly with either carry-in.
- R8: The `WIDTH` parameter selects the tree depth; a 64-bit instance (three levels of group cells) obeys R1 for random and corner operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH (16) | First operand |
| b_i | input | WIDTH (16) | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH (16) | Sum bits |
| cout_o | output | 1 | Carry out of the top bit |

## Verification
The bench aims at the carries that must cross group boundaries at each tree level. It includes a carry born at bit 0 that must travel the full word, and operands that are complements of each other, where only the carry-in decides the outcome. A design with a wrong sibling term in its carry cells, or with the child carries in the wrong order, would give a sum off by a power of 16 at a group edge. A design whose root propagate or generate was wrong would flip the carry-out in the all-propagate and all-generate cases. Alternating patterns catch propagate and generate being swapped, and the 64-bit instance catches errors in the level offsets of the tree.

// File: rtl/cla_tree_pkg.sv
package cla_tree_pkg;

  typedef struct packed {
    logic p;
    logic g;
  } pg_t;

  // Index of the first node of a tree level in the flat node array.
  function automatic int lvl_base(input int width, input int lvl);
    int base;
    int cnt;
    base = 0;
    cnt  = width;
    for (int k = 0; k < lvl; k++) begin
      base += cnt;
      cnt   = cnt / 4;
    end
    return base;
  endfunction

  // Number of radix-4 levels above the bit level.
  function automatic int tree_levels(input int width);
    int lv;
    int cnt;
    lv  = 0;
    cnt = width;
    while (cnt > 1) begin
      cnt = cnt / 4;
      lv++;
    end
    return lv;
  endfunction

  // Associative merge: hi is the more significant span.
  function automatic pg_t pg_join(input pg_t hi, input pg_t lo);
    pg_t r;
    r.p = hi.p & lo.p;
    r.g = hi.g | (hi.p & lo.g);
    return r;
  endfunction

endpackage

// File: rtl/cla_bit_pg.sv
module cla_bit_pg
  import cla_tree_pkg::*;
(
  input  logic a_bit,
  input  logic b_bit,
  output pg_t  pg_o
);
  assign pg_o.p = a_bit ^ b_bit;
  assign pg_o.g = a_bit & b_bit;
endmodule

// File: rtl/cla_pg4.sv
module cla_pg4
  import cla_tree_pkg::*;
(
  input  pg_t [3:0] kid_i,
  output pg_t       grp_o
);
  pg_t upper;
  pg_t lower;

  assign upper = pg_join(kid_i[3], kid_i[2]);
  assign lower = pg_join(kid_i[1], kid_i[0]);
  assign grp_o = pg_join(upper, lower);
endmodule

// File: rtl/cla_carry4.sv
module cla_carry4
  import cla_tree_pkg::*;
(
  input  pg_t [2:0] kid_i,
  input  logic      cin_i,
  output logic [3:0] cy_o
);
  assign cy_o[0] = cin_i;
  assign cy_o[1] = kid_i[0].g | (kid_i[0].p & cin_i);
  assign cy_o[2] = kid_i[1].g | (kid_i[1].p & kid_i[0].g)
                 | (kid_i[1].p & kid_i[0].p & cin_i);
  assign cy_o[3] = kid_i[2].g | (kid_i[2].p & kid_i[1].g)
                 | (kid_i[2].p & kid_i[1].p & kid_i[0].g)
                 | (kid_i[2].p & kid_i[1].p & kid_i[0].p & cin_i);
endmodule

// File: rtl/cla_tree_adder.sv
module cla_tree_adder
  import cla_tree_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  localparam int LEVELS = tree_levels(WIDTH);
  localparam int TOTAL  = lvl_base(WIDTH, LEVELS + 1);
  localparam int ROOT   = TOTAL - 1;

  pg_t  node_pg [TOTAL];
  logic node_cy [TOTAL];
  pg_t  root_pg;

  // Leaf level: one node per bit.
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    cla_bit_pg u_bit (
      .a_bit (a_i[i]),
      .b_bit (b_i[i]),
      .pg_o  (node_pg[i])
    );
    assign sum_o[i] = node_pg[i].p ^ node_cy[i];
  end

  // Group levels: upward (p,g) reduction, downward carry hand-off.
  for (genvar lv = 0; lv < LEVELS; lv++) begin : g_lvl
    localparam int CB = lvl_base(WIDTH, lv);
    localparam int PB = lvl_base(WIDTH, lv + 1);
    localparam int NP = WIDTH >> (2 * (lv + 1));
    for (genvar n = 0; n < NP; n++) begin : g_node
      logic [3:0] cy_w;
      cla_pg4 u_pg4 (
        .kid_i ({node_pg[CB+4*n+3], node_pg[CB+4*n+2],
                 node_pg[CB+4*n+1], node_pg[CB+4*n]}),
        .grp_o (node_pg[PB+n])
      );
      cla_carry4 u_cy4 (
        .kid_i ({node_pg[CB+4*n+2], node_pg[CB+4*n+1], node_pg[CB+4*n]}),
        .cin_i (node_cy[PB+n]),
        .cy_o  (cy_w)
      );
      for (genvar k = 0; k < 4; k++) begin : g_kid
        assign node_cy[CB+4*n+k] = cy_w[k];
      end
    end
  end

  assign node_cy[ROOT] = cin_i;
  assign root_pg       = node_pg[ROOT];
  assign cout_o        = root_pg.g | (root_pg.p & cin_i);
endmodule

// File: rtl/cla_tree_adder_chk.sv
module cla_tree_adder_chk #(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             cin_i,
  input logic [WIDTH-1:0] sum_i,
  input logic             cout_i,
  input logic             root_p,
  input logic             root_g
);
  always_comb begin
    // R1: ports match the arithmetic sum
    assert_sum_matches_R1: assert ({cout_i, sum_i} ==
      ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i}))
      else $error("R1 sum mismatch");
    // R4: root propagate set exactly when every bit propagates
    assert_root_prop_R4: assert (root_p == (&(a_i ^ b_i)))
      else $error("R4 root propagate wrong");
    // R4: propagate and generate are never both set at the root
    assert_pg_exclusive_R4: assert (!(root_p && root_g))
      else $error("R4 root p and g both set");
    // R3: a generating word always carries out
    assert_root_gen_R3: assert (!root_g || cout_i)
      else $error("R3 generate without carry-out");
    // R2: a word that neither generates nor propagates never carries out
    assert_no_carry_R2: assert (root_g || root_p || !cout_i)
      else $error("R2 carry-out without cause");
  end
endmodule

bind cla_tree_adder cla_tree_adder_chk #(.WIDTH(WIDTH)) chk_i (
  .a_i    (a_i),
  .b_i    (b_i),
  .cin_i  (cin_i),
  .sum_i  (sum_o),
  .cout_i (cout_o),
  .root_p (root_pg.p),
  .root_g (root_pg.g)
);

// File: tb/cla_tree_adder_tb_top.sv
`timescale 1ns/1ps
module cla_tree_adder_tb_top;
  localparam int W  = 16;
  localparam int WL = 64;
  localparam int NV = 12;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [W-1:0]  a, b, s;
  logic          ci, co;
  logic [WL-1:0] al, bl, sl;
  logic          cil, col;

  int checks = 0;
  int errors = 0;

  cla_tree_adder #(.WIDTH(W)) dut_i (
    .a_i(a), .b_i(b), .cin_i(ci), .sum_o(s), .cout_o(co));
  cla_tree_adder #(.WIDTH(WL)) dut64_i (
    .a_i(al), .b_i(bl), .cin_i(cil), .sum_o(sl), .cout_o(col));

  // {cin, a, b}
  localparam logic [32:0] VEC [NV] = '{
    {1'b0, 16'h0000, 16'h0000},
    {1'b1, 16'h0000, 16'h0000},
    {1'b0, 16'h1234, 16'h4321},
    {1'b1, 16'h8000, 16'h8000},
    {1'b0, 16'h7FFF, 16'h0001},
    {1'b1, 16'hFFFF, 16'h0000},
    {1'b0, 16'hDEAD, 16'hBEEF},
    {1'b1, 16'h0F0F, 16'hF0F0},
    {1'b0, 16'h3333, 16'hCCCD},
    {1'b1, 16'hFFFE, 16'h0001},
    {1'b0, 16'h00FF, 16'hFF01},
    {1'b1, 16'h5A5A, 16'hA5A4}
  };

  task automatic check(input string req, input logic [64:0] got,
                       input logic [64:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic run16(input string req, input logic [W-1:0] x,
                       input logic [W-1:0] y, input logic c);
    logic [W:0] exp;
    @(negedge clk);
    a = x; b = y; ci = c;
    #1;
    exp = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
    check(req, {48'd0, co, s}, {48'd0, exp});
  endtask

  task automatic run64(input string req, input logic [WL-1:0] x,
                       input logic [WL-1:0] y, input logic c);
    logic [WL:0] exp;
    @(negedge clk);
    al = x; bl = y; cil = c;
    #1;
    exp = {1'b0, x} + {1'b0, y} + {{WL{1'b0}}, c};
    check(req, {col, sl}, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R1 watchdog expired: got hang expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    a = '0; b = '0; ci = 1'b0;
    al = '0; bl = '0; cil = 1'b0;
    repeat (2) @(posedge clk);

    // R1: vector table
    for (int i = 0; i < NV; i++)
      run16("R1 table", VEC[i][31:16], VEC[i][15:0], VEC[i][32]);

    // R2: no bit generates, no carry-in -> OR, no carry-out
    @(negedge clk); a = 16'hF0F0; b = 16'h0F0F; ci = 1'b0; #1;
    check("R2 no generate", {48'd0, co, s}, {48'd0, 1'b0, 16'hFFFF});
    @(negedge clk); a = 16'h1248; b = 16'h8421; ci = 1'b0; #1;
    check("R2 no generate", {48'd0, co, s}, {48'd0, 1'b0, 16'h9669});

    // R3: full generate -> carry-out whatever the carry-in
    for (int c = 0; c < 2; c++) begin
      @(negedge clk); a = 16'hFFFF; b = 16'hFFFF; ci = c[0]; #1;
      check("R3 generate", {64'd0, co}, {64'd0, 1'b1});
    end

    // R4: full propagate -> cout = cin, sum = ~cin everywhere
    for (int c = 0; c < 2; c++) begin
      @(negedge clk); a = 16'hC3A5; b = 16'h3C5A; ci = c[0]; #1;
      check("R4 propagate", {48'd0, co, s},
            {48'd0, c[0], {W{~c[0]}}});
    end

    // R5: generate at bit 0 travels the whole word
    @(negedge clk); a = 16'h0001; b = 16'hFFFF; ci = 1'b0; #1;
    check("R5 long carry", {48'd0, co, s}, {48'd0, 1'b1, 16'h0000});

    // R6: carries across 4-bit and 16-bit group edges
    run16("R6 nibble edge", 16'h0008, 16'h0008, 1'b0);
    run16("R6 nibble edge", 16'h0800, 16'h0800, 1'b0);
    run16("R6 byte edge",   16'h00FF, 16'h0001, 1'b0);
    run64("R6 16-bit edge", 64'h0000_0000_0000_FFFF, 64'h1, 1'b0);
    run64("R6 32-bit edge", 64'h0000_0000_FFFF_FFFF, 64'h0, 1'b1);

    // R7: alternating patterns
    for (int c = 0; c < 2; c++) begin
      run16("R7 alternating", 16'hAAAA, 16'h5555, c[0]);
      run16("R7 alternating", 16'hAAAA, 16'hAAAA, c[0]);
      run16("R7 alternating", 16'h5555, 16'h5555, c[0]);
      run64("R7 alternating", {4{16'hAAAA}}, {4{16'h5555}}, c[0]);
    end

    // R8: 64-bit, three-level tree
    run64("R8 wide corner", {WL{1'b1}}, 64'h1, 1'b0);
    run64("R8 wide corner", {WL{1'b1}}, {WL{1'b1}}, 1'b1);
    run64("R8 wide corner", 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0);
    for (int i = 0; i < 500; i++)
      run64("R8 wide random", {$urandom, $urandom}, {$urandom, $urandom},
            1'($urandom));

    // R1: random 16-bit
    for (int i = 0; i < 1000; i++)
      run16("R1 random", 16'($urandom), 16'($urandom), 1'($urandom));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule